// File: doc/BRIEF.md
# Bus Cycle Watcher and Instruction Stepper

This block sits beside an eight-bit CPU core with a multiplexed control bus (memory request, read, write and first-machine-cycle strobes) and exposes the core's T-state and M-cycle counters. On every memory access it decides whether the cycle is an opcode fetch, a data read or a data write. It reports that decision as one of three registered, active-low event strobes, which a breakpoint or trace unit with eight address comparators consumes.

The same block owns the wait line that goes into the core. With stepping off, the external wait request passes straight through. With stepping on, it pulls wait low in the middle of every opcode fetch, so the core parks in T2 with its read still pending. A one-cycle step pulse lets exactly one fetch through. The block also registers the core's fetch request-inhibit flag. This flag is only set once wait has actually gone high, so a parked fetch never ends with the core latching an undriven data bus (0xFF) as an opcode.

Top module: `zbus_watch`

## Requirements
- R1: A cycle is classified only when `t_state` equals 2 (binary 010); a classification made at any other T-state is none, so all three event strobes read high in the cycle after it.
- R2: No event is produced from a clock edge at which `wait_n` (the block's own output) is low, so a T2 stretched by waits yields exactly one event for the bus cycle.
- R3: A fetch event (`evt_fetch_n` low) is `bus_rd_n`, `bus_mreq_n` and `bus_m1_n` all low at the deciding edge.
- R4: A read event (`evt_rd_n` low) is `bus_rd_n` and `bus_mreq_n` low with `bus_m1_n` high at the deciding edge.
- R5: A write event (`evt_wr_n` low) is `bus_wr_n` and `bus_mreq_n` low with `bus_m1_n` high at the deciding edge. The classification uses only the bus strobes.
- R6: Event strobes are registered. They change on the rising edge that ends the deciding T2, stay unchanged until the next rising edge, and read high again after the following edge unless a new decision is made.
- R7: `fetch_inhibit` is high for the one cycle after a rising edge at which `m_cycle` is 1, `t_state` is 2 and `wait_n` is high. It is low otherwise, including the whole time a fetch is parked.
- R8: While stepping mode is off, `wait_n` equals `ext_wait_n` combinationally.
- R9: While stepping mode is on and no step is granted, `wait_n` is low whenever `m_cycle` is 1 and `t_state` is 2. A `step_pulse` sampled high grants one step. The grant is consumed at the edge where a fetch T2 completes with `wait_n` high, so the next fetch parks again. Outside fetch T2, `wait_n` follows `ext_wait_n`.
- R10: During and right after reset, all event strobes are high, `fetch_inhibit` is low, stepping is off with no grant, and `wait_n` equals `ext_wait_n`.
- R11: `step_on` is registered. Stepping mode takes effect one clock after `step_on` is sampled, and `step_pulse` has no effect while mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t_state | input | 3 | T-state counter of the core |
| m_cycle | input | 3 | M-cycle counter of the core (1 = fetch cycle) |
| bus_mreq_n | input | 1 | Memory request strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_m1_n | input | 1 | First machine cycle strobe, active low |
| ext_wait_n | input | 1 | External wait request, active low |
| step_on | input | 1 | Stepping mode request, level |
| step_pulse | input | 1 | One-cycle step request |
| wait_n | output | 1 | Wait line driven into the core, active low |
| evt_fetch_n | output | 1 | Opcode fetch event strobe, active low |
| evt_rd_n | output | 1 | Memory read event strobe, active low |
| evt_wr_n | output | 1 | Memory write event strobe, active low |
| fetch_inhibit | output | 1 | Registered fetch request-inhibit flag to the core |

## Verification
`wait_n` is combinational, so the bench checks it one time unit after new inputs settle, in the same cycle. The three event strobes and `fetch_inhibit` are due one rising edge after the deciding inputs. The bench samples them at the following falling edge, and it also checks, just before that rising edge, that they still hold their previous values. Stepping mode and the step grant each add one register. The bench's model therefore updates its mode and grant only at the edge, and it checks how many stall cycles a fetch sees against the cycle in which the pulse was given.

// File: rtl/zbw_pkg.sv
// Package: shared widths, bus-cycle kind encoding and event indices for
// the bus cycle watcher. Assumes a 3-bit T-state and M-cycle counter.
package zbw_pkg;
    localparam int TS_W    = 3;
    localparam int MC_W    = 3;
    localparam int NUM_EVT = 3;

    // Kind of memory cycle seen at the decision point
    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_READ  = 2'd2,
        KIND_WRITE = 2'd3
    } bus_kind_e;

    // Index of each event strobe in the registered strobe vector
    localparam int EVT_FETCH = 0;
    localparam int EVT_READ  = 1;
    localparam int EVT_WRITE = 2;
endpackage

// File: rtl/zbw_classify.sv
// Classifier: combinational decode of the bus strobes into a cycle kind.
// It only yields a kind when the T-state is the decision state and the
// wait line seen by the core is high. Assumes active-low bus strobes.
module zbw_classify
    import zbw_pkg::*;
#(
    parameter int DECIDE_TS = 2
) (
    input  logic [TS_W-1:0] t_state,
    input  logic            wait_n,
    input  logic            mreq_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            m1_n,
    output bus_kind_e       kind
);
    localparam logic [TS_W-1:0] DECIDE_V = TS_W'(DECIDE_TS);

    logic at_decide;
    assign at_decide = (t_state == DECIDE_V) && wait_n && !mreq_n;

    // Pick one kind; fetch needs M1 low, read and write need M1 high
    always_comb begin
        kind = KIND_NONE;
        if (at_decide) begin
            if (!m1_n && !rd_n)
                kind = KIND_FETCH;
            else if (m1_n && !rd_n)
                kind = KIND_READ;
            else if (m1_n && !wr_n)
                kind = KIND_WRITE;
        end
    end
endmodule

// File: rtl/zbw_event_reg.sv
// Event register: turns the decided kind into registered active-low
// strobes, one per kind, valid for the cycle after the decision edge.
// Assumes a synchronous active-low reset.
module zbw_event_reg
    import zbw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  bus_kind_e          kind,
    output logic [NUM_EVT-1:0] strobe_n
);
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
        localparam bus_kind_e MY_KIND = bus_kind_e'(k + 1);
        // Hold this kind's strobe low for one cycle after its decision
        always_ff @(posedge clk) begin
            if (!rst_n)
                strobe_n[k] <= 1'b1;
            else
                strobe_n[k] <= (kind != MY_KIND);
        end
    end
endmodule

// File: rtl/zbw_stepper.sv
// Stepper: registers stepping mode and the one-shot step grant, and
// forms the wait line into the core. With no grant it parks every fetch
// in the decision T-state; a completed fetch T2 consumes the grant.
// Assumes step_pulse is one clock wide and synchronous to clk.
module zbw_stepper
    import zbw_pkg::*;
#(
    parameter int DECIDE_TS = 2,
    parameter int FETCH_MC  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] t_state,
    input  logic [MC_W-1:0] m_cycle,
    input  logic            ext_wait_n,
    input  logic            step_on,
    input  logic            step_pulse,
    output logic            wait_n
);
    localparam logic [TS_W-1:0] DECIDE_V = TS_W'(DECIDE_TS);
    localparam logic [MC_W-1:0] FETCH_V  = MC_W'(FETCH_MC);

    logic mode_q;
    logic grant_q;
    logic fetch_t2;
    logic park;
    logic fetch_done;

    assign fetch_t2   = (m_cycle == FETCH_V) && (t_state == DECIDE_V);
    assign park       = mode_q && !grant_q && fetch_t2;
    assign wait_n     = ext_wait_n && !park;
    assign fetch_done = fetch_t2 && wait_n;

    // Register the stepping mode request
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else
            mode_q <= step_on;
    end

    // Set the grant on a step pulse, drop it once a fetch T2 completes
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_q)
            grant_q <= 1'b0;
        else if (step_pulse)
            grant_q <= 1'b1;
        else if (fetch_done)
            grant_q <= 1'b0;
    end
endmodule

// File: rtl/zbw_inhibit.sv
// Fetch request-inhibit: registers the flag the core uses to stop its
// fetch request. It is set only when the fetch T2 actually completes,
// i.e. the wait line seen by the core is high. Synchronous reset.
module zbw_inhibit
    import zbw_pkg::*;
#(
    parameter int DECIDE_TS = 2,
    parameter int FETCH_MC  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] t_state,
    input  logic [MC_W-1:0] m_cycle,
    input  logic            wait_n,
    output logic            inhibit
);
    localparam logic [TS_W-1:0] DECIDE_V = TS_W'(DECIDE_TS);
    localparam logic [MC_W-1:0] FETCH_V  = MC_W'(FETCH_MC);

    // Raise the inhibit for one cycle after a non-waited fetch T2
    always_ff @(posedge clk) begin
        if (!rst_n)
            inhibit <= 1'b0;
        else
            inhibit <= (m_cycle == FETCH_V) && (t_state == DECIDE_V) && wait_n;
    end
endmodule

// File: rtl/zbus_watch.sv
// Top: bus cycle watcher and instruction stepper. Classifies memory
// cycles into fetch/read/write event strobes, drives the core's wait
// line for single stepping and registers the fetch request-inhibit.
// Assumes the core samples wait in T2 and holds the strobes through it.
module zbus_watch
    import zbw_pkg::*;
#(
    parameter int DECIDE_TS = 2,
    parameter int FETCH_MC  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] t_state,
    input  logic [MC_W-1:0] m_cycle,
    input  logic            bus_mreq_n,
    input  logic            bus_rd_n,
    input  logic            bus_wr_n,
    input  logic            bus_m1_n,
    input  logic            ext_wait_n,
    input  logic            step_on,
    input  logic            step_pulse,
    output logic            wait_n,
    output logic            evt_fetch_n,
    output logic            evt_rd_n,
    output logic            evt_wr_n,
    output logic            fetch_inhibit
);
    bus_kind_e          kind;
    logic [NUM_EVT-1:0] strobe_n;

    zbw_stepper #(.DECIDE_TS(DECIDE_TS), .FETCH_MC(FETCH_MC)) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .t_state    (t_state),
        .m_cycle    (m_cycle),
        .ext_wait_n (ext_wait_n),
        .step_on    (step_on),
        .step_pulse (step_pulse),
        .wait_n     (wait_n)
    );

    zbw_classify #(.DECIDE_TS(DECIDE_TS)) u_cls (
        .t_state (t_state),
        .wait_n  (wait_n),
        .mreq_n  (bus_mreq_n),
        .rd_n    (bus_rd_n),
        .wr_n    (bus_wr_n),
        .m1_n    (bus_m1_n),
        .kind    (kind)
    );

    zbw_event_reg u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .strobe_n (strobe_n)
    );

    zbw_inhibit #(.DECIDE_TS(DECIDE_TS), .FETCH_MC(FETCH_MC)) u_inh (
        .clk     (clk),
        .rst_n   (rst_n),
        .t_state (t_state),
        .m_cycle (m_cycle),
        .wait_n  (wait_n),
        .inhibit (fetch_inhibit)
    );

    assign evt_fetch_n = strobe_n[EVT_FETCH];
    assign evt_rd_n    = strobe_n[EVT_READ];
    assign evt_wr_n    = strobe_n[EVT_WRITE];
endmodule

// File: rtl/zbw_check.sv
// Checker: temporal properties of the watcher at its ports, bound to
// every instance of the top module.
module zbw_check
    import zbw_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [TS_W-1:0] t_state,
    input logic [MC_W-1:0] m_cycle,
    input logic            ext_wait_n,
    input logic            step_on,
    input logic            wait_n,
    input logic            evt_fetch_n,
    input logic            evt_rd_n,
    input logic            evt_wr_n,
    input logic            fetch_inhibit
);
    AST_EVT_ONLY_T2: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_fetch_n || !evt_rd_n || !evt_wr_n) |-> ($past(t_state) == 3'd2)); // R1
    AST_EVT_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_fetch_n || !evt_rd_n || !evt_wr_n) |-> $past(wait_n)); // R2
    AST_FETCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_fetch_n |-> (evt_rd_n && evt_wr_n)); // R3
    AST_INH_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_inhibit |-> ($past(wait_n) && $past(m_cycle) == 3'd1)); // R7
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step_on) |-> (wait_n == ext_wait_n)); // R8
    AST_PARK_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_n && ext_wait_n) |-> (m_cycle == 3'd1 && t_state == 3'd2)); // R9
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (evt_fetch_n && evt_rd_n && evt_wr_n && !fetch_inhibit)); // R10
endmodule

bind zbus_watch zbw_check u_zbw_check (
    .clk           (clk),
    .rst_n         (rst_n),
    .t_state       (t_state),
    .m_cycle       (m_cycle),
    .ext_wait_n    (ext_wait_n),
    .step_on       (step_on),
    .wait_n        (wait_n),
    .evt_fetch_n   (evt_fetch_n),
    .evt_rd_n      (evt_rd_n),
    .evt_wr_n      (evt_wr_n),
    .fetch_inhibit (fetch_inhibit)
);

// File: tb/tb_zbus_watch.sv
module tb_zbus_watch;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] t_state = 3'd0;
    logic [2:0] m_cycle = 3'd1;
    logic       bus_mreq_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_m1_n = 1'b1;
    logic       ext_wait_n = 1'b1, step_on = 1'b0, step_pulse = 1'b0;
    logic       wait_n, evt_fetch_n, evt_rd_n, evt_wr_n, fetch_inhibit;

    int nvec = 0;
    int nbad = 0;
    int cycles = 0;
    bit done = 0;

    // Bench model state, following the requirements
    bit m_mode = 0, m_grant = 0;
    bit e_f = 1, e_r = 1, e_w = 1, e_i = 0;
    int evt_count = 0;
    int last_stalls = 0;

    zbus_watch dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit model_wait();
        return ext_wait_n && !(m_mode && !m_grant && m_cycle == 3'd1 && t_state == 3'd2);
    endfunction

    // One clock: check wait_n now, outputs held before the edge, outputs after it
    task automatic step();
        bit w, nf, nr, nw, ni, ng, dec;
        #1;
        w = model_wait();
        chk(m_mode ? "R9 wait_n" : "R8 wait_n", wait_n, w);
        chk("R6 fetch held", evt_fetch_n, e_f);
        chk("R6 read held", evt_rd_n, e_r);
        chk("R6 write held", evt_wr_n, e_w);
        dec = (t_state == 3'd2) && w && !bus_mreq_n;
        nf = !(dec && !bus_m1_n && !bus_rd_n);
        nr = !(dec && bus_m1_n && !bus_rd_n);
        nw = !(dec && bus_m1_n && bus_rd_n && !bus_wr_n);
        ni = (m_cycle == 3'd1) && (t_state == 3'd2) && w;
        if (!m_mode) ng = 0;
        else if (step_pulse) ng = 1;
        else if (ni) ng = 0;
        else ng = m_grant;
        @(posedge clk);
        m_grant = ng;
        m_mode  = step_on;
        e_f = nf; e_r = nr; e_w = nw; e_i = ni;
        @(negedge clk);
        chk("R3 fetch", evt_fetch_n, e_f);
        chk("R4 read", evt_rd_n, e_r);
        chk("R5 write", evt_wr_n, e_w);
        chk("R7 inhibit", fetch_inhibit, e_i);
        if (t_state != 3'd2 || !w) begin
            chk("R1/R2 quiet", evt_fetch_n & evt_rd_n & evt_wr_n, 1'b1);
        end
        if (!evt_fetch_n || !evt_rd_n || !evt_wr_n) evt_count++;
    endtask

    task automatic idle();
        t_state = 3'd0; bus_mreq_n = 1; bus_rd_n = 1; bus_wr_n = 1; bus_m1_n = 1;
        ext_wait_n = 1; step_pulse = 0;
    endtask

    // kind: 0 fetch, 1 read, 2 write; pulse_at: stall cycle that carries the step pulse
    task automatic bus_cycle(input int kind, input logic [2:0] mc, input int nwait,
                             input int pulse_at);
        int s;
        evt_count = 0;
        m_cycle = mc;
        t_state = 3'd1; bus_mreq_n = 0; bus_m1_n = (kind == 0) ? 1'b0 : 1'b1;
        bus_rd_n = (kind == 2) ? 1'b1 : 1'b0; bus_wr_n = 1; ext_wait_n = 1;
        step();
        t_state = 3'd2; bus_wr_n = (kind == 2) ? 1'b0 : 1'b1;
        for (int i = 0; i < nwait; i++) begin
            ext_wait_n = 0;
            step();
        end
        ext_wait_n = 1;
        s = 0;
        while (!model_wait() && s < 40) begin
            step_pulse = (s == pulse_at);
            step();
            s++;
        end
        step_pulse = 0;
        last_stalls = s;
        step();
        t_state = 3'd3;
        step();
        idle();
        step();
        chk("R2 one event per cycle", evt_count == 1, 1'b1);
    endtask

    initial begin : watchdog
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 fetch", evt_fetch_n, 1'b1);
        chk("R10 read", evt_rd_n, 1'b1);
        chk("R10 write", evt_wr_n, 1'b1);
        chk("R10 inhibit", fetch_inhibit, 1'b0);
        ext_wait_n = 0; #1 chk("R10 wait", wait_n, 1'b0);
        ext_wait_n = 1; #1 chk("R10 wait", wait_n, 1'b1);
        rst_n = 1;
        step();

        // Sweep, stepping off: all T-states, two M-cycles, all strobe/wait mixes
        for (int ts = 0; ts < 8; ts++)
            for (int mc = 1; mc <= 2; mc++)
                for (int v = 0; v < 64; v++) begin
                    t_state = 3'(ts); m_cycle = 3'(mc);
                    {bus_mreq_n, bus_rd_n, bus_wr_n, bus_m1_n, ext_wait_n, step_pulse} = 6'(v);
                    step();
                end
        idle(); step();

        // Whole cycles with inserted waits, stepping off
        for (int k = 0; k < 3; k++)
            for (int n = 0; n < 4; n++)
                bus_cycle(k, (k == 0) ? 3'd1 : 3'd2, n, -1);

        // R11: mode takes effect one clock after step_on
        m_cycle = 3'd1; t_state = 3'd2; bus_mreq_n = 0; bus_rd_n = 0; bus_m1_n = 0;
        step_on = 1;
        #1 chk("R11 mode not yet", wait_n, 1'b1);
        idle(); step();
        m_cycle = 3'd1; t_state = 3'd2;
        #1 chk("R11 mode active", wait_n, 1'b0);
        idle(); step();

        // R9: a pulse releases exactly one fetch; reads are not parked
        bus_cycle(0, 3'd1, 0, 2);
        chk("R9 stalls before pulse", last_stalls == 3, 1'b1);
        bus_cycle(1, 3'd2, 1, -1);
        chk("R9 read not parked", last_stalls == 0, 1'b1);
        bus_cycle(0, 3'd1, 2, 4);
        chk("R9 grant consumed", last_stalls == 5, 1'b1);
        // Pulse given early: next fetch passes, the one after parks
        step_pulse = 1; step(); step_pulse = 0;
        bus_cycle(0, 3'd1, 0, -1);
        chk("R9 early grant", last_stalls == 0, 1'b1);
        bus_cycle(2, 3'd2, 0, -1);
        bus_cycle(0, 3'd1, 1, 1);
        chk("R9 parks again", last_stalls == 2, 1'b1);

        // Sweep, stepping on: grant and park interplay with every input mix
        for (int ts = 0; ts < 8; ts++)
            for (int mc = 1; mc <= 2; mc++)
                for (int v = 0; v < 64; v++) begin
                    t_state = 3'(ts); m_cycle = 3'(mc);
                    {bus_mreq_n, bus_rd_n, bus_wr_n, bus_m1_n, ext_wait_n, step_pulse} = 6'(v);
                    step();
                end

        // R11: pulse ignored once mode is off
        idle(); step_on = 0; step(); step();
        step_pulse = 1; step(); step_pulse = 0;
        step_on = 1; step();
        bus_cycle(0, 3'd1, 0, 0);
        chk("R11 pulse ignored while off", last_stalls == 1, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule